// File: doc/BRIEF.md
# Sub-Word Register Access Bridge

This block connects a host that issues byte, halfword and word register accesses to a peripheral register file that only takes aligned 32-bit accesses. A narrow read fetches the containing word and returns the addressed lane, zero-extended. A narrow write fetches the containing word, replaces the addressed lane and writes the whole word back.

The peripheral can drop a register write that follows another one too closely, because it crosses into a slower clock domain. The bridge therefore keeps a programmable minimum number of cycles between downstream register writes and stalls the host while that window is open. Writes to the data-port word are exempt and may go out back to back. The transfer-mode halfword and the command halfword share one word. A halfword write to transfer mode is held in a shadow word and not sent. A later halfword write to command merges into that shadow and goes out as one 32-bit write, so the peripheral sees both fields at once.

Top module: `subword_bridge`

## Requirements
- R1: Every downstream access uses a word address, with address bits 1:0 equal to zero.
- R2: A read with `h_size` 0 (byte) returns the byte selected by address bits 1:0 in `h_rdata[7:0]`. A read with `h_size` 1 (halfword) returns bits 31:16 when address bit 1 is set and bits 15:0 otherwise, in `h_rdata[15:0]`. All upper bits are zero. A read with `h_size` 2 or 3 returns the full word.
- R3: A byte or halfword write, with its value in the low bits of `h_wdata`, issues one downstream read of the containing word and then one downstream write in which only the selected lane differs.
- R4: Two downstream writes to words other than the data port are at least `cfg_gap` cycles apart. A write held back by this rule issues exactly `cfg_gap` cycles after the previous spaced write, and `h_ready` stays low until it has issued.
- R5: Writes to the data-port word (offset 0x20) issue without waiting and do not restart the spacing window.
- R6: A halfword write to offset 0x0C (transfer mode) reads the word at 0x0C, merges the value into bits 15:0 and stores the result in the shadow word. No downstream write takes place. Byte and word writes to that word are handled normally.
- R7: A halfword write to offset 0x0E (command) merges the value into bits 31:16 of the shadow word without any downstream read, then issues the combined word as one write to 0x0C.
- R8: A word write is sent unchanged. Reads are never delayed by the spacing window.
- R9: After reset `h_ready` and `dn_valid` are low, the shadow word is zero and the spacing window is closed, so the first write is not delayed.
- R10: `h_ready` is a one-cycle pulse. Counting the cycles from the acceptance edge to the cycle in which `h_ready` is high, and with no spacing stall, the latencies are: read 3, word write 2, command halfword 3, transfer-mode halfword 3, other narrow write 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_gap | input | GAP_W | Minimum number of cycles between spaced writes |
| h_valid | input | 1 | Host request; held until `h_ready` |
| h_we | input | 1 | 1 = write, 0 = read |
| h_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| h_addr | input | ADDR_W | Byte address |
| h_wdata | input | 32 | Write value, right-aligned for narrow writes |
| h_ready | output | 1 | Completion pulse; read data is valid in the same cycle |
| h_rdata | output | 32 | Read result |
| dn_valid | output | 1 | Downstream access strobe |
| dn_we | output | 1 | Downstream write |
| dn_addr | output | ADDR_W | Downstream word address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, valid the cycle after the read strobe |

## Verification
Read results are due on `h_ready` three cycles after acceptance. Word writes complete in two cycles and other narrow writes in four. A downstream write lands in the peripheral model on the clock edge after its strobe. The bench therefore samples `h_rdata`, the strobe counts and the peripheral contents at the falling edge of the cycle in which `h_ready` is high, never earlier. A spaced write is expected exactly `cfg_gap` cycles after the previous one. The bench timestamps each downstream strobe at a falling edge, checks every gap against that value, and checks latencies only where no spacing stall can apply.

// File: rtl/sb_pkg.sv
package sb_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } size_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_RDW,
      ST_MERGE,
      ST_WAIT,
      ST_DONE
   } state_e;

   typedef enum logic [1:0] {
      K_PLAIN,
      K_XFER,
      K_CMD
   } kind_e;
endpackage

// File: rtl/sb_lane_unit.sv
module sb_lane_unit
   import sb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  size_e             size_i,
   input  logic [1:0]        lane_i,
   input  logic [DATA_W-1:0] old_i,
   input  logic [DATA_W-1:0] new_i,
   input  logic [DATA_W-1:0] rd_i,
   output logic [DATA_W-1:0] merged_o,
   output logic [DATA_W-1:0] extract_o
);
   localparam int NBYTES = DATA_W / 8;
   localparam int SHW    = $clog2(DATA_W);

   initial begin
      assert (DATA_W == 32) else $error("sb_lane_unit: DATA_W must be 32");
   end

   // merge: each byte lane picks the new byte or keeps the old one
   for (genvar i = 0; i < NBYTES; i++) begin : g_lane
      localparam logic [1:0] LI = 2'(i);
      logic       sel;
      logic [7:0] src;
      always_comb begin
         case (size_i)
            SZ_BYTE: begin
               sel = (lane_i == LI);
               src = new_i[7:0];
            end
            SZ_HALF: begin
               sel = (lane_i[1] == LI[1]);
               src = new_i[8*(i%2) +: 8];
            end
            default: begin
               sel = 1'b1;
               src = new_i[8*i +: 8];
            end
         endcase
      end
      assign merged_o[8*i +: 8] = sel ? src : old_i[8*i +: 8];
   end

   // extract: shift the addressed lane down and clear the rest
   logic [SHW-1:0]    sh;
   logic [DATA_W-1:0] shifted;

   always_comb begin
      case (size_i)
         SZ_BYTE: sh = {lane_i, 3'b000};
         SZ_HALF: sh = {lane_i[1], 4'b0000};
         default: sh = '0;
      endcase
   end

   assign shifted = rd_i >> sh;

   always_comb begin
      case (size_i)
         SZ_BYTE: extract_o = {{(DATA_W-8){1'b0}}, shifted[7:0]};
         SZ_HALF: extract_o = {{(DATA_W-16){1'b0}}, shifted[15:0]};
         default: extract_o = shifted;
      endcase
   end
endmodule

// File: rtl/sb_gap_timer.sv
module sb_gap_timer #(
   parameter int GAP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [GAP_W-1:0] len_i,
   output logic             ready_o
);
   initial begin
      assert (GAP_W >= 1) else $error("sb_gap_timer: GAP_W must be positive");
   end

   logic [GAP_W-1:0] cnt_q;

   // loaded with len-1 on the issuing edge, so the next spaced write
   // is allowed exactly len cycles after this one
   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start_i)
         cnt_q <= (len_i == '0) ? '0 : len_i - 1'b1;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign ready_o = (cnt_q == '0);

   assert_start_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> ready_o);
endmodule

// File: rtl/sb_shadow.sv
module sb_shadow #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q_o <= '0;
      else if (load_i)
         q_o <= d_i;
   end
endmodule

// File: rtl/subword_bridge.sv
module subword_bridge
   import sb_pkg::*;
#(
   parameter int               ADDR_W    = 8,
   parameter int               DATA_W    = 32,
   parameter int               GAP_W     = 16,
   parameter logic [ADDR_W-1:0] DPORT_OFS = 'h20,
   parameter logic [ADDR_W-1:0] XFER_OFS  = 'h0C,
   parameter logic [ADDR_W-1:0] CMD_OFS   = 'h0E
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GAP_W-1:0]  cfg_gap,
   input  logic              h_valid,
   input  logic              h_we,
   input  logic [1:0]        h_size,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [DATA_W-1:0] h_wdata,
   output logic              h_ready,
   output logic [DATA_W-1:0] h_rdata,
   output logic              dn_valid,
   output logic              dn_we,
   output logic [ADDR_W-1:0] dn_addr,
   output logic [DATA_W-1:0] dn_wdata,
   input  logic [DATA_W-1:0] dn_rdata
);
   localparam int WA_W = ADDR_W - 2;
   localparam logic [WA_W-1:0] DPORT_WA = DPORT_OFS[ADDR_W-1:2];
   localparam logic [WA_W-1:0] XFER_WA  = XFER_OFS[ADDR_W-1:2];
   localparam logic [WA_W-1:0] CMD_WA   = CMD_OFS[ADDR_W-1:2];

   initial begin
      assert (ADDR_W >= 3) else $error("subword_bridge: ADDR_W too small");
      assert (DATA_W == 32) else $error("subword_bridge: DATA_W must be 32");
      assert (XFER_WA == CMD_WA) else $error("subword_bridge: mode and command must share a word");
      assert (XFER_OFS[1] != CMD_OFS[1]) else $error("subword_bridge: mode and command need distinct halves");
      assert (XFER_OFS[0] == 1'b0 && CMD_OFS[0] == 1'b0) else $error("subword_bridge: halfword offsets must be even");
   end

   // request registers
   state_e              state_q;
   logic                we_q;
   size_e               size_q;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [DATA_W-1:0]   work_q;
   kind_e               kind_q;
   logic                dport_q;

   // decode of the incoming request
   logic [WA_W-1:0] in_wa;
   logic            in_word;
   kind_e           in_kind;

   assign in_wa   = h_addr[ADDR_W-1:2];
   assign in_word = h_size[1];

   always_comb begin
      in_kind = K_PLAIN;
      if (h_we && size_e'(h_size) == SZ_HALF && in_wa == XFER_WA)
         in_kind = (h_addr[1] == XFER_OFS[1]) ? K_XFER : K_CMD;
   end

   // helpers
   logic              gap_rdy;
   logic              go_wr;
   logic              shadow_ld;
   logic [DATA_W-1:0] shadow_q;
   logic [DATA_W-1:0] lane_old;
   logic [DATA_W-1:0] merged;
   logic [DATA_W-1:0] extracted;

   assign go_wr     = (state_q == ST_WAIT) && (dport_q || gap_rdy);
   assign shadow_ld = (state_q == ST_RDW) && we_q && (kind_q == K_XFER);
   assign lane_old  = (state_q == ST_MERGE) ? shadow_q : dn_rdata;

   sb_lane_unit #(.DATA_W(DATA_W)) lane_i (
      .size_i    (size_q),
      .lane_i    (addr_q[1:0]),
      .old_i     (lane_old),
      .new_i     (wdata_q),
      .rd_i      (dn_rdata),
      .merged_o  (merged),
      .extract_o (extracted)
   );

   sb_gap_timer #(.GAP_W(GAP_W)) gap_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (go_wr && !dport_q),
      .len_i   (cfg_gap),
      .ready_o (gap_rdy)
   );

   sb_shadow #(.DATA_W(DATA_W)) shadow_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (shadow_ld),
      .d_i    (merged),
      .q_o    (shadow_q)
   );

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         we_q    <= 1'b0;
         size_q  <= SZ_WORD;
         addr_q  <= '0;
         wdata_q <= '0;
         work_q  <= '0;
         kind_q  <= K_PLAIN;
         dport_q <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (h_valid) begin
                  we_q    <= h_we;
                  size_q  <= size_e'(h_size);
                  addr_q  <= h_addr;
                  wdata_q <= h_wdata;
                  work_q  <= h_wdata;
                  kind_q  <= in_kind;
                  dport_q <= (in_wa == DPORT_WA);
                  if (!h_we)
                     state_q <= ST_RD;
                  else if (in_word)
                     state_q <= ST_WAIT;
                  else if (in_kind == K_CMD)
                     state_q <= ST_MERGE;
                  else
                     state_q <= ST_RD;
               end
            end
            ST_RD:   state_q <= ST_RDW;
            ST_RDW: begin
               if (!we_q) begin
                  work_q  <= extracted;
                  state_q <= ST_DONE;
               end else if (kind_q == K_XFER) begin
                  state_q <= ST_DONE;
               end else begin
                  work_q  <= merged;
                  state_q <= ST_WAIT;
               end
            end
            ST_MERGE: begin
               work_q  <= merged;
               state_q <= ST_WAIT;
            end
            ST_WAIT: begin
               if (go_wr)
                  state_q <= ST_DONE;
            end
            default: begin
               kind_q  <= K_PLAIN;
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign h_ready  = (state_q == ST_DONE);
   assign h_rdata  = work_q;
   assign dn_valid = (state_q == ST_RD) || go_wr;
   assign dn_we    = (state_q == ST_WAIT);
   assign dn_addr  = {addr_q[ADDR_W-1:2], 2'b00};
   assign dn_wdata = work_q;

   // assertions
   assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      h_ready |=> !h_ready);

   assert_gap_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dn_valid && dn_we && dn_addr[ADDR_W-1:2] != DPORT_WA) |-> gap_rdy);

   assert_dport_free_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && dport_q) |-> dn_valid);

   assert_cmd_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == K_CMD && state_q != ST_IDLE) |-> !(dn_valid && !dn_we));

   assert_xfer_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_q == K_XFER && state_q != ST_IDLE) |-> !(dn_valid && dn_we));
endmodule

// File: tb/subword_bridge_tb_top.sv
module subword_bridge_tb_top;
   localparam int G = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] cfg_gap;
   logic        h_valid, h_we;
   logic [1:0]  h_size;
   logic [7:0]  h_addr;
   logic [31:0] h_wdata;
   logic        h_ready;
   logic [31:0] h_rdata;
   logic        dn_valid, dn_we;
   logic [7:0]  dn_addr;
   logic [31:0] dn_wdata;
   logic [31:0] dn_rdata;

   always #5 clk = ~clk;

   subword_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap),
      .h_valid(h_valid), .h_we(h_we), .h_size(h_size), .h_addr(h_addr),
      .h_wdata(h_wdata), .h_ready(h_ready), .h_rdata(h_rdata),
      .dn_valid(dn_valid), .dn_we(dn_we), .dn_addr(dn_addr),
      .dn_wdata(dn_wdata), .dn_rdata(dn_rdata)
   );

   int cyc = 0, n_chk = 0, n_fail = 0, rd_cnt = 0, wr_cnt = 0;
   int last_sp = -1, sp_gap = 0;
   bit prev_rdy = 0;
   logic [31:0] pm [64];
   logic [31:0] exp_mem [64];
   logic [31:0] exp_shadow;

   function automatic logic [31:0] pat(input int i);
      return 32'hA500_0000 ^ (i * 32'h0103_0507);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // peripheral register file stand-in: read data one cycle after strobe
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 64; i++) pm[i] <= pat(i);
      end else if (dn_valid) begin
         if (dn_we) pm[dn_addr[7:2]] <= dn_wdata;
         else       dn_rdata <= pm[dn_addr[7:2]];
      end
   end

   // per-cycle monitor
   always @(negedge clk) begin
      if (rst_n) begin
         if (h_ready) chk(!prev_rdy, "R10 ready pulse", 32'(h_ready), 32'(0));
         prev_rdy = h_ready;
         if (dn_valid) begin
            chk(dn_addr[1:0] == 2'b00, "R1 aligned address", 32'(dn_addr), 32'(dn_addr & 8'hFC));
            if (dn_we) begin
               wr_cnt++;
               if (dn_addr[7:2] != 6'd8) begin
                  if (last_sp >= 0) begin
                     sp_gap = cyc - last_sp;
                     chk(sp_gap >= G, "R4 minimum gap", 32'(sp_gap), 32'(G));
                  end
                  last_sp = cyc;
               end
            end else begin
               rd_cnt++;
            end
         end
      end
   end

   task automatic acc(input bit we, input logic [1:0] sz, input logic [7:0] a,
                      input logic [31:0] wd, input int exp_lat, input string req);
      int w = int'(a[7:2]);
      int rd0 = rd_cnt, wr0 = wr_cnt, lat = 0;
      bit isx, isc;
      logic [31:0] old, mrg, expr, got;
      isx = we && sz == 2'd1 && w == 3 && !a[1];
      isc = we && sz == 2'd1 && w == 3 && a[1];
      old = isc ? exp_shadow : exp_mem[w];
      mrg = old;
      case (sz)
         2'd0:    mrg[8*a[1:0] +: 8] = wd[7:0];
         2'd1:    mrg[16*a[1] +: 16] = wd[15:0];
         default: mrg = wd;
      endcase
      case (sz)
         2'd0:    expr = (exp_mem[w] >> (8*a[1:0])) & 32'hFF;
         2'd1:    expr = (exp_mem[w] >> (16*a[1])) & 32'hFFFF;
         default: expr = exp_mem[w];
      endcase
      @(negedge clk);
      h_valid = 1'b1; h_we = we; h_size = sz; h_addr = a; h_wdata = wd;
      do begin
         @(negedge clk);
         lat++;
      end while (!h_ready && lat < 2000);
      got = h_rdata;
      h_valid = 1'b0;
      if (lat >= 2000) chk(0, {req, " watchdog"}, 32'(lat), 32'(exp_lat));
      if (exp_lat > 0) chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
      if (!we) begin
         chk(got == expr, req, got, expr);
      end else if (isx) begin
         exp_shadow = mrg;
         chk(wr_cnt == wr0, {req, " no write"}, 32'(wr_cnt - wr0), 32'(0));
         chk(rd_cnt - rd0 == 1, {req, " one read"}, 32'(rd_cnt - rd0), 32'(1));
         chk(pm[w] == exp_mem[w], {req, " peripheral unchanged"}, pm[w], exp_mem[w]);
      end else begin
         exp_mem[w] = mrg;
         chk(wr_cnt - wr0 == 1, {req, " one write"}, 32'(wr_cnt - wr0), 32'(1));
         chk(rd_cnt - rd0 == ((isc || sz[1]) ? 0 : 1), {req, " read count"},
             32'(rd_cnt - rd0), 32'((isc || sz[1]) ? 0 : 1));
         chk(pm[w] == exp_mem[w], req, pm[w], exp_mem[w]);
      end
   endtask

   initial begin
      rst_n = 1'b0; cfg_gap = 16'(G);
      h_valid = 1'b0; h_we = 1'b0; h_size = 2'd2; h_addr = '0; h_wdata = '0;
      for (int i = 0; i < 64; i++) exp_mem[i] = pat(i);
      exp_shadow = '0;
      repeat (3) begin
         @(negedge clk);
         chk(!h_ready, "R9 ready low in reset", 32'(h_ready), 32'(0));
         chk(!dn_valid, "R9 no access in reset", 32'(dn_valid), 32'(0));
      end
      @(negedge clk); rst_n = 1'b1;

      acc(1, 2'd2, 8'h00, 32'h1122_3344, 2, "R9 R8 first word write");
      acc(1, 2'd2, 8'h04, 32'h5566_7788, 0, "R8 word write");
      chk(sp_gap == G, "R4 exact gap", 32'(sp_gap), 32'(G));
      acc(1, 2'd2, 8'h20, 32'hD0D0_0001, 2, "R5 data port write");
      acc(1, 2'd2, 8'h20, 32'hD0D0_0002, 2, "R5 data port back to back");
      acc(1, 2'd2, 8'h08, 32'h99AA_BBCC, 0, "R8 word write after data port");
      chk(sp_gap == G, "R5 window not restarted", 32'(sp_gap), 32'(G));
      acc(0, 2'd2, 8'h00, '0, 3, "R8 read during window");
      acc(0, 2'd0, 8'h00, '0, 3, "R2 byte lane 0");
      acc(0, 2'd0, 8'h01, '0, 3, "R2 byte lane 1");
      acc(0, 2'd0, 8'h02, '0, 3, "R2 byte lane 2");
      acc(0, 2'd0, 8'h07, '0, 3, "R2 byte lane 3");
      acc(0, 2'd1, 8'h04, '0, 3, "R2 low half");
      acc(0, 2'd1, 8'h0B, '0, 3, "R2 high half");
      acc(1, 2'd1, 8'h0E, 32'h0000_BEEF, 0, "R7 R9 command with zero shadow");
      acc(1, 2'd1, 8'h0C, 32'h0000_1234, 3, "R6 transfer mode held");
      acc(0, 2'd2, 8'h0C, '0, 3, "R6 peripheral word unchanged");
      acc(1, 2'd1, 8'h0E, 32'h0000_CAFE, 0, "R7 command merged");
      acc(1, 2'd0, 8'h05, 32'h0000_005A, 0, "R3 byte write");
      acc(1, 2'd1, 8'h0A, 32'h0000_7E57, 0, "R3 halfword write");
      acc(1, 2'd0, 8'h0D, 32'h0000_0099, 0, "R6 byte write to mode word");
      repeat (G + 2) @(negedge clk);
      acc(1, 2'd0, 8'h06, 32'h0000_003C, 4, "R10 R3 narrow write latency");
      repeat (G + 2) @(negedge clk);
      acc(1, 2'd1, 8'h0E, 32'h0000_F00D, 3, "R10 R7 command latency");
      acc(0, 2'd1, 8'h06, '0, 3, "R2 half after narrow write");
      acc(0, 2'd3, 8'h0C, '0, 3, "R2 size 3 reads word");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule